// File: doc/BRIEF.md
# Single-Operand Bit-Manipulation Execute Unit

This unit is the execute step for one class of a 32-bit RISC core's instructions: those that read a single source register and write at most one result. It takes the instruction word, the source operand, the current carry flag and the privilege state. From these it produces the result, a register-write enable with the destination index, a new carry value with its own write enable, and two fault flags: one for illegal instructions and one for privilege traps. The unit is purely combinational. An input `valid` qualifies every enable and every flag.

The class covers the following operations:
- a one-bit right shift in three forms: sign fill, zero fill, and a fill that rotates through the carry;
- sign extension from a byte or from a halfword;
- leading-zero count, present only when the `CLZ_EN` parameter is set;
- byte reversal and halfword exchange;
- data-cache and instruction-cache hints.

The cache hints do no data work. They only check the privilege state. The register file, pipeline control, exception dispatch and cache maintenance belong to the surrounding core.

Top module: `bitop_unit`

## Requirements
- R1: The unit recognises an operation only when the instruction has bits [31:26] = 6'b100100, bits [15:11] = 0, and one of these function codes in bits [10:0]: sra 0x001, src 0x021, srl 0x041, sext8 0x060, sext16 0x061, clz 0x0E0, swapb 0x1E0, swaph 0x1E2. The destination index is bits [25:21].
- R2: sra shifts right by one and fills bit 31 with the sign bit. srl shifts right by one and fills bit 31 with zero. Both set `carry_we`, with `carry_out` equal to operand bit 0.
- R3: src shifts right by one and puts `carry_in` into result bit 31. It sets `carry_out` to operand bit 0, so the carry and the operand rotate as one 33-bit value.
- R4: clz returns the count of leading zero bits of the operand. It returns 32 for a zero operand.
- R5: When `CLZ_EN` is 0, the clz code raises `illegal`, and `rd_we` and `carry_we` stay low.
- R6: swapb reverses the byte order of the word. swaph swaps the upper and lower halfwords.
- R7: sext8 copies bit 7 into bits [31:8]. sext16 copies bit 15 into bits [31:16].
- R8: A destination index of 0 holds `rd_we` low. The shift operations still assert `carry_we`.
- R9: A cache hint has bits [31:26] = 6'b100100 and bits [25:21] = 0, and bits [15:11] may hold any value. Bits [10:0] must either match the pattern ?00?11?01?0 (data cache) or equal 0x068 (instruction cache). A hint raises no write enable and no `illegal`. It raises `priv_trap` exactly when `user_mode` is 1.
- R10: Every other encoding raises `illegal`, with `rd_we`, `carry_we` and `priv_trap` low.
- R11: With `valid` low, `rd_we`, `carry_we`, `illegal` and `priv_trap` are all 0. `carry_we` is asserted only for sra, srl and src.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| opa | input | 32 | Source register value |
| carry_in | input | 1 | Carry flag before the instruction |
| user_mode | input | 1 | 1 when the core runs unprivileged |
| result | output | 32 | Value to write to the destination |
| rd_idx | output | 5 | Destination register index |
| rd_we | output | 1 | Destination register write enable |
| carry_out | output | 1 | New carry flag value |
| carry_we | output | 1 | Carry flag write enable |
| illegal | output | 1 | Illegal-instruction indication |
| priv_trap | output | 1 | Privilege trap for a hint issued in user mode |

## Verification
The checker evaluates the control relations on every input change:
- nothing is asserted without `valid`;
- an illegal encoding never writes;
- a trap occurs only in user mode and never writes;
- `rd_we` is never raised for destination 0;
- each carry write carries operand bit 0.

Only the bench scenarios can show that each result value is correct: the shift fills, the rotate through carry, the zero-count limit, the byte orders and the sign fills. The bench also shows that the exact function codes, the hint patterns and the parameter setting with the count removed are decoded as intended.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    localparam int unsigned INSTR_W = 32;
    localparam int unsigned REG_IDX_W = 5;
    localparam int unsigned FUNC_W = 11;

    localparam logic [5:0] MAJOR_BITOP = 6'b100100;

    localparam logic [FUNC_W-1:0] FN_SRA    = 11'h001;
    localparam logic [FUNC_W-1:0] FN_SRC    = 11'h021;
    localparam logic [FUNC_W-1:0] FN_SRL    = 11'h041;
    localparam logic [FUNC_W-1:0] FN_SEXT8  = 11'h060;
    localparam logic [FUNC_W-1:0] FN_SEXT16 = 11'h061;
    localparam logic [FUNC_W-1:0] FN_CLZ    = 11'h0E0;
    localparam logic [FUNC_W-1:0] FN_SWAPB  = 11'h1E0;
    localparam logic [FUNC_W-1:0] FN_SWAPH  = 11'h1E2;
    localparam logic [FUNC_W-1:0] FN_IHINT  = 11'h068;

    typedef enum logic [3:0] {
        K_NONE,
        K_SRA,
        K_SRL,
        K_SRC,
        K_SEXT8,
        K_SEXT16,
        K_CLZ,
        K_SWAPB,
        K_SWAPH,
        K_HINT
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     wr_reg;
        logic     wr_carry;
        logic     bad;
        logic     hint;
    } dec_t;

    // Leading-zero count; returns the full width for an all-zero word.
    function automatic logic [7:0] lead_zeros(input logic [INSTR_W-1:0] v, input int unsigned w);
        logic [7:0] n;
        n = 8'(w);
        for (int unsigned i = 0; i < w; i++) begin
            if (v[i]) n = 8'(w - 1 - i);
        end
        return n;
    endfunction

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
    import bitop_pkg::*;
#(
    parameter bit CLZ_EN = 1'b1
) (
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic [5:0]           major;
    logic [REG_IDX_W-1:0] dst;
    logic [REG_IDX_W-1:0] third;
    logic [FUNC_W-1:0]    fn;
    logic                 unused_src_field;
    logic                 data_hint;

    assign major = instr[31:26];
    assign dst   = instr[25:21];
    assign third = instr[15:11];
    assign fn    = instr[FUNC_W-1:0];
    assign unused_src_field = ^instr[20:16];

    always_comb begin
        casez (fn)
            11'b?00?11?01?0: data_hint = 1'b1;
            default:         data_hint = 1'b0;
        endcase
    end

    always_comb begin
        dec = '{kind: K_NONE, wr_reg: 1'b0, wr_carry: 1'b0, bad: 1'b1, hint: 1'b0};
        if (major == MAJOR_BITOP) begin
            if (third == '0) begin
                unique case (fn)
                    FN_SRA:    dec = '{K_SRA,    1'b1, 1'b1, 1'b0, 1'b0};
                    FN_SRL:    dec = '{K_SRL,    1'b1, 1'b1, 1'b0, 1'b0};
                    FN_SRC:    dec = '{K_SRC,    1'b1, 1'b1, 1'b0, 1'b0};
                    FN_SEXT8:  dec = '{K_SEXT8,  1'b1, 1'b0, 1'b0, 1'b0};
                    FN_SEXT16: dec = '{K_SEXT16, 1'b1, 1'b0, 1'b0, 1'b0};
                    FN_SWAPB:  dec = '{K_SWAPB,  1'b1, 1'b0, 1'b0, 1'b0};
                    FN_SWAPH:  dec = '{K_SWAPH,  1'b1, 1'b0, 1'b0, 1'b0};
                    FN_CLZ: begin
                        if (CLZ_EN) dec = '{K_CLZ, 1'b1, 1'b0, 1'b0, 1'b0};
                    end
                    default: ;
                endcase
            end
            if (dec.bad && dst == '0 && (data_hint || fn == FN_IHINT)) begin
                dec = '{K_HINT, 1'b0, 1'b0, 1'b0, 1'b1};
            end
        end
    end

endmodule

// File: rtl/bitop_datapath.sv
module bitop_datapath
    import bitop_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter bit          CLZ_EN = 1'b1
) (
    input  op_kind_e          kind,
    input  logic [DATA_W-1:0] opa,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              carry_out
);
    localparam int unsigned BYTES = DATA_W / 8;
    localparam int unsigned HALF  = DATA_W / 2;

    logic [DATA_W-1:0] byte_rev;
    logic [DATA_W-1:0] half_rev;
    logic [DATA_W-1:0] zcount;
    logic              fill;

    for (genvar b = 0; b < BYTES; b++) begin : g_brev
        assign byte_rev[8*b +: 8] = opa[DATA_W-8-8*b +: 8];
    end

    assign half_rev = {opa[HALF-1:0], opa[DATA_W-1:HALF]};

    if (CLZ_EN) begin : g_clz
        logic [INSTR_W-1:0] wide;
        logic [7:0]         cnt;
        assign wide   = INSTR_W'(opa);
        assign cnt    = lead_zeros(wide, DATA_W);
        assign zcount = DATA_W'(cnt);
    end else begin : g_noclz
        assign zcount = '0;
    end

    always_comb begin
        unique case (kind)
            K_SRA:   fill = opa[DATA_W-1];
            K_SRC:   fill = carry_in;
            default: fill = 1'b0;
        endcase
    end

    assign carry_out = opa[0];

    always_comb begin
        unique case (kind)
            K_SRA, K_SRL, K_SRC: result = {fill, opa[DATA_W-1:1]};
            K_SEXT8:  result = {{(DATA_W-8){opa[7]}}, opa[7:0]};
            K_SEXT16: result = {{(DATA_W-16){opa[15]}}, opa[15:0]};
            K_CLZ:    result = zcount;
            K_SWAPB:  result = byte_rev;
            K_SWAPH:  result = half_rev;
            default:  result = '0;
        endcase
    end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter bit          CLZ_EN = 1'b1
) (
    input  logic                 valid,
    input  logic [INSTR_W-1:0]   instr,
    input  logic [DATA_W-1:0]    opa,
    input  logic                 carry_in,
    input  logic                 user_mode,
    output logic [DATA_W-1:0]    result,
    output logic [REG_IDX_W-1:0] rd_idx,
    output logic                 rd_we,
    output logic                 carry_out,
    output logic                 carry_we,
    output logic                 illegal,
    output logic                 priv_trap
);
    dec_t dec;

    bitop_decode #(.CLZ_EN(CLZ_EN)) u_decode (
        .instr (instr),
        .dec   (dec)
    );

    bitop_datapath #(.DATA_W(DATA_W), .CLZ_EN(CLZ_EN)) u_datapath (
        .kind      (dec.kind),
        .opa       (opa),
        .carry_in  (carry_in),
        .result    (result),
        .carry_out (carry_out)
    );

    assign rd_idx    = instr[25:21];
    assign rd_we     = valid & dec.wr_reg & (rd_idx != '0);
    assign carry_we  = valid & dec.wr_carry;
    assign illegal   = valid & dec.bad;
    assign priv_trap = valid & dec.hint & user_mode;

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk
    import bitop_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input logic                 valid,
    input logic [INSTR_W-1:0]   instr,
    input logic [DATA_W-1:0]    opa,
    input logic                 carry_in,
    input logic                 user_mode,
    input logic [DATA_W-1:0]    result,
    input logic [REG_IDX_W-1:0] rd_idx,
    input logic                 rd_we,
    input logic                 carry_out,
    input logic                 carry_we,
    input logic                 illegal,
    input logic                 priv_trap
);
    logic known;
    logic unused_chk;
    assign known = !$isunknown({valid, instr, opa, user_mode, carry_in});
    assign unused_chk = ^result;

    always_comb begin
        if (known) begin
            assert_valid_gate_R11: assert (valid || !(rd_we || carry_we || illegal || priv_trap))
                else $error("enable without valid");
            assert_carry_src_R2: assert (!carry_we || carry_out == opa[0])
                else $error("carry write not from operand bit 0");
            assert_illegal_quiet_R10: assert (!illegal || (!rd_we && !carry_we && !priv_trap))
                else $error("illegal op with side effect");
            assert_trap_user_R9: assert (!priv_trap || (user_mode && !rd_we && !carry_we && !illegal))
                else $error("trap outside user mode or with writes");
            assert_zero_dst_R8: assert (!rd_we || rd_idx != '0)
                else $error("write to index 0");
            assert_dst_field_R1: assert (rd_idx == instr[25:21])
                else $error("destination index mismatch");
        end
    end

endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/bitop_unit_bench.sv
module bitop_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid;
    logic [31:0] instr;
    logic [31:0] opa;
    logic        carry_in;
    logic        user_mode;

    logic [31:0] res_a, res_b;
    logic [4:0]  idx_a, idx_b;
    logic        we_a, we_b, co_a, co_b, cwe_a, cwe_b, ill_a, ill_b, trp_a, trp_b;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    bitop_unit #(.CLZ_EN(1'b1)) u_bitop_unit (
        .valid(valid), .instr(instr), .opa(opa), .carry_in(carry_in), .user_mode(user_mode),
        .result(res_a), .rd_idx(idx_a), .rd_we(we_a), .carry_out(co_a), .carry_we(cwe_a),
        .illegal(ill_a), .priv_trap(trp_a));

    bitop_unit #(.CLZ_EN(1'b0)) u_bitop_unit_noclz (
        .valid(valid), .instr(instr), .opa(opa), .carry_in(carry_in), .user_mode(user_mode),
        .result(res_b), .rd_idx(idx_b), .rd_we(we_b), .carry_out(co_b), .carry_we(cwe_b),
        .illegal(ill_b), .priv_trap(trp_b));

    function automatic logic [31:0] enc(input logic [4:0] rd, input logic [4:0] rb, input logic [10:0] f);
        return {6'b100100, rd, 5'd3, rb, f};
    endfunction

    function automatic int ref_clz(input logic [31:0] v);
        for (int k = 31; k >= 0; k--) if (v[k]) return 31 - k;
        return 32;
    endfunction

    task automatic expect_ok(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Compares one unit against values derived from the requirements.
    task automatic judge(input bit clz_on, input logic [31:0] r, input logic [4:0] ix, input logic we,
                         input logic co, input logic cwe, input logic il, input logic tp);
        logic [10:0] f;
        logic        ours, wr, cw, illx, hint;
        logic [31:0] er;
        f    = instr[10:0];
        ours = instr[31:26] == 6'b100100;
        wr = 0; cw = 0; er = 0; illx = 1; hint = 0;
        if (ours && instr[15:11] == 0) begin
            illx = 0;
            case (f)
                11'h001: begin er = {opa[31], opa[31:1]}; cw = 1; end
                11'h041: begin er = {1'b0, opa[31:1]}; cw = 1; end
                11'h021: begin er = {carry_in, opa[31:1]}; cw = 1; end
                11'h060: er = {{24{opa[7]}}, opa[7:0]};
                11'h061: er = {{16{opa[15]}}, opa[15:0]};
                11'h0E0: begin er = ref_clz(opa); illx = !clz_on; end
                11'h1E0: er = {opa[7:0], opa[15:8], opa[23:16], opa[31:24]};
                11'h1E2: er = {opa[15:0], opa[31:16]};
                default: illx = 1;
            endcase
            wr = !illx;
            if (illx) cw = 0;
        end
        if (illx && ours && instr[25:21] == 0 &&
            (((f & 11'h36D) == 11'h064) || f == 11'h068)) begin
            illx = 0; hint = 1;
        end
        wr = wr && instr[25:21] != 0;
        if (!valid) begin wr = 0; cw = 0; illx = 0; hint = 0; end
        expect_ok("R1", "rd_idx", 32'(ix), 32'(instr[25:21]));
        expect_ok(hint ? "R9" : (instr[25:21] == 0 ? "R8" : "R1"), "rd_we", 32'(we), 32'(wr));
        expect_ok(valid ? "R2" : "R11", "carry_we", 32'(cwe), 32'(cw));
        expect_ok(clz_on ? "R10" : "R5", "illegal", 32'(il), 32'(illx));
        expect_ok("R9", "priv_trap", 32'(tp), 32'(hint && user_mode));
        if (wr) expect_ok("R4", "result", r, er);
        if (cw) expect_ok("R3", "carry_out", 32'(co), 32'(opa[0]));
    endtask

    task automatic apply(input logic v, input logic [31:0] i, input logic [31:0] a, input logic c, input logic u);
        @(negedge clk);
        valid = v; instr = i; opa = a; carry_in = c; user_mode = u;
        #1;
        judge(1'b1, res_a, idx_a, we_a, co_a, cwe_a, ill_a, trp_a);
        judge(1'b0, res_b, idx_b, we_b, co_b, cwe_b, ill_b, trp_b);
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        valid = 0; instr = 0; opa = 0; carry_in = 0; user_mode = 0;
        void'($urandom(32'h5EED_0123));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R11 idle state
        expect_ok("R11", "idle rd_we", 32'(we_a), 0);
        expect_ok("R11", "idle illegal", 32'(ill_a), 0);

        // R2 directed shifts
        apply(1, enc(5'd4, 0, 11'h001), 32'h8000_0001, 0, 0);
        expect_ok("R2", "sra", res_a, 32'hC000_0000);
        expect_ok("R2", "sra carry", 32'(co_a), 1);
        apply(1, enc(5'd4, 0, 11'h041), 32'h8000_0001, 0, 0);
        expect_ok("R2", "srl", res_a, 32'h4000_0000);
        // R3 rotate through carry
        apply(1, enc(5'd4, 0, 11'h021), 32'h0000_0002, 1, 0);
        expect_ok("R3", "src", res_a, 32'h8000_0001);
        expect_ok("R3", "src carry", 32'(co_a), 0);
        // R4 clz corners
        apply(1, enc(5'd7, 0, 11'h0E0), 32'h0, 0, 0);
        expect_ok("R4", "clz zero", res_a, 32);
        apply(1, enc(5'd7, 0, 11'h0E0), 32'h0001_0000, 0, 0);
        expect_ok("R4", "clz mid", res_a, 15);
        apply(1, enc(5'd7, 0, 11'h0E0), 32'h8000_0000, 0, 0);
        expect_ok("R4", "clz top", res_a, 0);
        // R5 disabled clz
        expect_ok("R5", "clz off illegal", 32'(ill_b), 1);
        expect_ok("R5", "clz off we", 32'(we_b), 0);
        // R6 swaps
        apply(1, enc(5'd9, 0, 11'h1E0), 32'h1122_3344, 0, 0);
        expect_ok("R6", "swapb", res_a, 32'h4433_2211);
        apply(1, enc(5'd9, 0, 11'h1E2), 32'h1122_3344, 0, 0);
        expect_ok("R6", "swaph", res_a, 32'h3344_1122);
        // R7 sign extension
        apply(1, enc(5'd9, 0, 11'h060), 32'h0000_0080, 0, 0);
        expect_ok("R7", "sext8", res_a, 32'hFFFF_FF80);
        apply(1, enc(5'd9, 0, 11'h061), 32'h1234_7FFF, 0, 0);
        expect_ok("R7", "sext16", res_a, 32'h0000_7FFF);
        // R8 zero destination with shift
        apply(1, enc(5'd0, 0, 11'h041), 32'h0000_0003, 0, 0);
        expect_ok("R8", "rd0 we", 32'(we_a), 0);
        expect_ok("R8", "rd0 carry_we", 32'(cwe_a), 1);
        // R9 hints
        apply(1, enc(5'd0, 5'd6, 11'h064), 32'hFFFF_FFFF, 0, 1);
        expect_ok("R9", "dhint user trap", 32'(trp_a), 1);
        apply(1, enc(5'd0, 5'd6, 11'h068), 32'hFFFF_FFFF, 0, 0);
        expect_ok("R9", "ihint super", 32'(trp_a | ill_a | we_a), 0);
        // R10 bad encodings
        apply(1, enc(5'd4, 5'd1, 11'h001), 32'h5, 0, 0);
        expect_ok("R10", "rb nonzero", 32'(ill_a), 1);
        apply(1, {6'b100101, 26'h0}, 32'h5, 0, 0);
        expect_ok("R10", "other major", 32'(ill_a), 1);

        for (int n = 0; n < 4000; n++) begin
            logic [10:0] f;
            logic [31:0] word;
            logic [4:0]  rd, rb;
            case ($urandom_range(0, 11))
                0: f = 11'h001;  1: f = 11'h021;  2: f = 11'h041;
                3: f = 11'h060;  4: f = 11'h061;  5: f = 11'h0E0;
                6: f = 11'h1E0;  7: f = 11'h1E2;  8: f = 11'h068;
                9: f = (11'($urandom) & ~11'h36D) | 11'h064;
                default: f = 11'($urandom);
            endcase
            rd = ($urandom_range(0, 5) == 0) ? 5'd0 : 5'($urandom);
            rb = ($urandom_range(0, 7) == 0) ? 5'($urandom) : 5'd0;
            word = enc(rd, rb, f);
            if ($urandom_range(0, 15) == 0) word[31:26] = 6'($urandom);
            apply($urandom_range(0, 9) != 0, word,
                  ($urandom_range(0, 9) == 0) ? 32'h0 : ($urandom >> $urandom_range(0, 31)),
                  1'($urandom), 1'($urandom));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule